// File: doc/BRIEF.md
# Rename Admission Controller

This block sits beside the rename stage of an out-of-order core. Each cycle it decides how many of the instructions offered to rename may move on toward dispatch, and whether the stage must hold back the stages in front of it. It keeps its own copy of the free space last reported by the reorder buffer, the issue queue and the load/store queue. It also keeps a count of instructions that have been renamed but not yet dispatched. It treats that count as credit already spent, so a reported free count that is a few cycles old never lets too much through.

Within the cycle's limit it walks the offered slots in program order. It stops at a slot that would need more free physical registers than remain, and at a slot that must wait for the machine to drain. A slot must wait when it is marked as serialize-before, or when it directly follows a serialize-after instruction. While such a wait is in progress, nothing is admitted. The wait ends in the first cycle that sees an empty reorder buffer and no instructions in flight. In that cycle the waiting instruction is let through at the head.

All pins are plain control and count signals. The offer is a count (`avail`) and the answer is a count (`admit`) in the same cycle, so the block needs no valid/ready handshake. Back-pressure toward earlier stages is the level `block_req`: when it is high, the offered instructions that were not admitted have to be presented again, starting from slot 0.

Top module: `rn_admit`

## Requirements
- R1: The usable reorder-buffer space and the usable issue-queue space each equal the stored reported count, minus the in-flight count, plus `disp_last`.
- R2: The usable load/store-queue space equals the stored reported count, minus the in-flight count, plus `lsq_disp_last`.
- R3: The tightest queue is the one with the smallest usable space. Ties go to the reorder buffer, then the issue queue, then the load/store queue. When `avail` is nonzero and the smallest space is below `avail`, `cause` gives that queue (1 = reorder buffer, 2 = issue queue, 3 = load/store queue). Otherwise `cause` is 0.
- R4: When the smallest usable space is zero or negative, `admit` is 0. In that case `block_req` is high whenever `avail` is nonzero.
- R5: `admit` never exceeds `avail`, `WIDTH` or the smallest usable space. `block_req` is high whenever `admit` is below `avail`.
- R6: Slot i carries its destination-register count in `slot_dst[i*DST_W +: DST_W]`. Admission stops before the first slot at which the running sum of destination counts would exceed `preg_free`.
- R7: A slot marked serialize-before (`slot_sb[i]`) stops admission there and raises `ser_stall`. The stall then holds with `admit` = 0 and `block_req` high until a cycle in which `rob_empty` is high and the in-flight count is 0. In that cycle slot 0 is admitted even though it carries the mark.
- R8: An admitted serialize-after slot (`slot_sa[i]`) makes slot i+1 behave as serialize-before. When it is the last slot admitted, a pending mark applies to slot 0 of the next cycle that reaches slot 0.
- R9: A pending mark is discarded in any cycle in which `rob_empty` is high and the in-flight count is 0.
- R10: The in-flight count becomes in-flight + `admit` − `disp_last` at each clock edge. A result below zero is clamped to 0, and `inflight_uflow` is high in that cycle.
- R11: A reported count is stored only in a cycle in which its valid flag is high, and it is used from the next cycle. While the flag is low, the reported value has no effect.
- R12: After reset, all stored counts and the in-flight count are 0, with no stall and no pending mark. Any nonzero offer is refused with `cause` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_rpt_vld | input | 1 | Reorder-buffer free count is valid this cycle |
| rob_rpt | input | CNT_W | Reported reorder-buffer free entries |
| iq_rpt_vld | input | 1 | Issue-queue free count is valid this cycle |
| iq_rpt | input | CNT_W | Reported issue-queue free entries |
| lsq_rpt_vld | input | 1 | Load/store-queue free count is valid this cycle |
| lsq_rpt | input | CNT_W | Reported load/store-queue free entries |
| disp_last | input | CNT_W | Instructions dispatched last cycle |
| lsq_disp_last | input | CNT_W | Instructions dispatched into the load/store queue last cycle |
| avail | input | CNT_W | Instructions offered to rename this cycle |
| slot_dst | input | WIDTH*DST_W | Destination-register count for each slot |
| slot_sb | input | WIDTH | Serialize-before mark for each slot |
| slot_sa | input | WIDTH | Serialize-after mark for each slot |
| preg_free | input | PREG_W | Free physical registers |
| rob_empty | input | 1 | Reorder buffer holds no instructions |
| admit | output | $clog2(WIDTH+1) | Instructions admitted this cycle, from slot 0 upward |
| block_req | output | 1 | Request to hold the earlier stages |
| ser_stall | output | 1 | Serialize stall is active or entered this cycle |
| cause | output | 2 | Queue that limited admission (0 when none did) |
| inflight_uflow | output | 1 | Dispatch count exceeded the in-flight count this cycle |

## Verification
The bench compares every output against a cycle model kept in the bench. Directed runs cover each limit on its own:
- a tight issue queue, then a tight load/store queue, which shows whether the right dispatch count is added back to each queue;
- equal queue spaces, which exposes the tie order;
- a destination-register shortage, which shows whether the running sum is used or only one slot's count;
- serialize-before and serialize-after sequences around drain cycles, which separate holding, releasing the head slot, and carrying or dropping the pending mark.

A long seeded random run then mixes all of these at once, including reports whose valid flag is low and oversized dispatch counts.

// File: rtl/rn_admit_pkg.sv
package rn_admit_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ROB  = 2'd1,
    CAUSE_IQ   = 2'd2,
    CAUSE_LSQ  = 2'd3
  } cause_e;

  localparam int NUM_QUEUES = 3;
endpackage

// File: rtl/rn_admit_credit.sv
// Holds one queue's last valid free report and turns it into usable space
// by charging in-flight instructions and crediting those just dispatched.
module rn_admit_credit #(
  parameter int CNT_W = 6,
  localparam int SW = CNT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rpt_vld,
  input  logic [CNT_W-1:0]     rpt,
  input  logic [CNT_W-1:0]     drained,
  input  logic [CNT_W-1:0]     inflight,
  output logic signed [SW-1:0] eff
);
  logic [CNT_W-1:0] stored_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       stored_q <= '0;
    else if (rpt_vld) stored_q <= rpt;
  end

  always_comb begin
    eff = $signed({2'b00, stored_q}) - $signed({2'b00, inflight})
        + $signed({2'b00, drained});
  end
endmodule

// File: rtl/rn_admit_minsel.sv
// Picks the tightest queue; a later queue wins only if strictly smaller.
module rn_admit_minsel #(
  parameter int CNT_W = 6,
  localparam int SW = CNT_W + 2
) (
  input  logic signed [SW-1:0] eff_rob,
  input  logic signed [SW-1:0] eff_iq,
  input  logic signed [SW-1:0] eff_lsq,
  output logic signed [SW-1:0] min_eff,
  output rn_admit_pkg::cause_e src
);
  always_comb begin
    min_eff = eff_rob;
    src     = rn_admit_pkg::CAUSE_ROB;
    if (eff_iq < min_eff) begin
      min_eff = eff_iq;
      src     = rn_admit_pkg::CAUSE_IQ;
    end
    if (eff_lsq < min_eff) begin
      min_eff = eff_lsq;
      src     = rn_admit_pkg::CAUSE_LSQ;
    end
  end
endmodule

// File: rtl/rn_admit_scan.sv
// In-order slot walk: stops at the limit, a serialize mark, or a register shortage.
module rn_admit_scan #(
  parameter int WIDTH  = 4,
  parameter int DST_W  = 2,
  parameter int PREG_W = 7,
  localparam int AW = $clog2(WIDTH + 1)
) (
  input  logic [AW-1:0]          lim,
  input  logic [WIDTH*DST_W-1:0] dst,
  input  logic [WIDTH-1:0]       sb_mark,
  input  logic [PREG_W-1:0]      preg_free,
  output logic [AW-1:0]          cnt,
  output logic                   sb_hit
);
  logic go;
  int   cum;

  always_comb begin
    go     = 1'b1;
    cum    = 0;
    cnt    = '0;
    sb_hit = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (go && (i < int'(lim))) begin
        if (sb_mark[i]) begin
          sb_hit = 1'b1;
          go     = 1'b0;
        end else if (cum + int'(dst[i*DST_W +: DST_W]) > int'(preg_free)) begin
          go = 1'b0;
        end else begin
          cum = cum + int'(dst[i*DST_W +: DST_W]);
          cnt = cnt + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rn_admit.sv
module rn_admit #(
  parameter int WIDTH  = 4,
  parameter int CNT_W  = 6,
  parameter int DST_W  = 2,
  parameter int PREG_W = 7,
  localparam int AW = $clog2(WIDTH + 1),
  localparam int SW = CNT_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rob_rpt_vld,
  input  logic [CNT_W-1:0]       rob_rpt,
  input  logic                   iq_rpt_vld,
  input  logic [CNT_W-1:0]       iq_rpt,
  input  logic                   lsq_rpt_vld,
  input  logic [CNT_W-1:0]       lsq_rpt,
  input  logic [CNT_W-1:0]       disp_last,
  input  logic [CNT_W-1:0]       lsq_disp_last,
  input  logic [CNT_W-1:0]       avail,
  input  logic [WIDTH*DST_W-1:0] slot_dst,
  input  logic [WIDTH-1:0]       slot_sb,
  input  logic [WIDTH-1:0]       slot_sa,
  input  logic [PREG_W-1:0]      preg_free,
  input  logic                   rob_empty,
  output logic [AW-1:0]          admit,
  output logic                   block_req,
  output logic                   ser_stall,
  output logic [1:0]             cause,
  output logic                   inflight_uflow
);
  import rn_admit_pkg::*;

  localparam int NQ = NUM_QUEUES;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] inflight_q;
  logic             stall_q;
  logic             pend_q;

  // Per-queue credit units: 0 reorder buffer, 1 issue queue, 2 load/store queue
  logic                 rpt_vld_a [NQ];
  logic [CNT_W-1:0]     rpt_a     [NQ];
  logic [CNT_W-1:0]     drain_a   [NQ];
  logic signed [SW-1:0] eff_a     [NQ];

  always_comb begin
    rpt_vld_a[0] = rob_rpt_vld;  rpt_a[0] = rob_rpt;  drain_a[0] = disp_last;
    rpt_vld_a[1] = iq_rpt_vld;   rpt_a[1] = iq_rpt;   drain_a[1] = disp_last;
    rpt_vld_a[2] = lsq_rpt_vld;  rpt_a[2] = lsq_rpt;  drain_a[2] = lsq_disp_last;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_credit
    rn_admit_credit #(.CNT_W(CNT_W)) u_credit (
      .clk      (clk),
      .rst_n    (rst_n),
      .rpt_vld  (rpt_vld_a[q]),
      .rpt      (rpt_a[q]),
      .drained  (drain_a[q]),
      .inflight (inflight_q),
      .eff      (eff_a[q])
    );
  end

  logic signed [SW-1:0] min_eff;
  cause_e               min_src;

  rn_admit_minsel #(.CNT_W(CNT_W)) u_minsel (
    .eff_rob (eff_a[0]),
    .eff_iq  (eff_a[1]),
    .eff_lsq (eff_a[2]),
    .min_eff (min_eff),
    .src     (min_src)
  );

  // Serialize state
  logic exit_ok, hold, bypass;
  always_comb begin
    exit_ok = rob_empty && (inflight_q == '0);
    hold    = stall_q && !exit_ok;
    bypass  = stall_q && exit_ok;
  end

  logic [WIDTH-1:0] sb_mark;
  always_comb begin
    sb_mark[0] = (slot_sb[0] || (pend_q && !exit_ok)) && !bypass;
  end
  for (genvar s = 1; s < WIDTH; s++) begin : g_mark
    always_comb sb_mark[s] = slot_sb[s] || slot_sa[s-1];
  end

  // Admission limit
  int          lim_i;
  logic [AW-1:0] lim;
  always_comb begin
    lim_i = (min_eff <= 0) ? 0 : int'(min_eff);
    if (int'(avail) < lim_i) lim_i = int'(avail);
    if (WIDTH < lim_i)       lim_i = WIDTH;
    if (hold)                lim_i = 0;
    lim = AW'(lim_i);
  end

  logic [AW-1:0] cnt;
  logic          sb_hit;

  rn_admit_scan #(.WIDTH(WIDTH), .DST_W(DST_W), .PREG_W(PREG_W)) u_scan (
    .lim       (lim),
    .dst       (slot_dst),
    .sb_mark   (sb_mark),
    .preg_free (preg_free),
    .cnt       (cnt),
    .sb_hit    (sb_hit)
  );

  always_comb begin
    admit     = cnt;
    block_req = hold || (int'(cnt) < int'(avail));
    ser_stall = hold || sb_hit;
    if (!hold && (avail != '0) && (int'(min_eff) < int'(avail))) cause = min_src;
    else                                                         cause = CAUSE_NONE;
  end

  // Pending serialize mark
  logic last_sa, pend_d;
  always_comb begin
    last_sa = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (int'(cnt) == i + 1) last_sa = slot_sa[i];
    end
    pend_d = (last_sa && !sb_hit) || (pend_q && !exit_ok && (lim_i == 0));
  end

  // In-flight count
  int               nx_i;
  logic [CNT_W-1:0] inflight_d;
  always_comb begin
    nx_i           = int'(inflight_q) + int'(cnt) - int'(disp_last);
    inflight_uflow = (nx_i < 0);
    if (nx_i < 0)            inflight_d = '0;
    else if (nx_i > CNT_MAX) inflight_d = CNT_W'(CNT_MAX);
    else                     inflight_d = CNT_W'(nx_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q <= '0;
      stall_q    <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      inflight_q <= inflight_d;
      stall_q    <= ser_stall;
      pend_q     <= pend_d;
    end
  end
endmodule

// File: rtl/rn_admit_chk.sv
module rn_admit_chk #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 6,
  localparam int AW = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] avail,
  input logic [AW-1:0]    admit,
  input logic             block_req,
  input logic             ser_stall,
  input logic [1:0]       cause,
  input logic             inflight_uflow,
  input logic             rob_empty,
  input logic             stall_q,
  input logic [CNT_W-1:0] inflight_q
);
  // R5
  admit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(admit) <= int'(avail)) && (int'(admit) <= WIDTH));

  // R5
  full_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !block_req |-> (int'(admit) == int'(avail)));

  // R3
  cause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 2'd0) |-> (block_req && (int'(admit) < int'(avail))));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !(rob_empty && inflight_q == '0)) |-> (ser_stall && admit == '0));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stall |-> block_req);

  // R7
  stall_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_stall |=> stall_q);

  // R10
  uflow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_uflow |=> (inflight_q == '0));
endmodule

bind rn_admit rn_admit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .avail          (avail),
  .admit          (admit),
  .block_req      (block_req),
  .ser_stall      (ser_stall),
  .cause          (cause),
  .inflight_uflow (inflight_uflow),
  .rob_empty      (rob_empty),
  .stall_q        (stall_q),
  .inflight_q     (inflight_q)
);

// File: tb/tb_rn_admit.sv
module tb_rn_admit;
  localparam int WIDTH  = 4;
  localparam int CNT_W  = 6;
  localparam int DST_W  = 2;
  localparam int PREG_W = 7;
  localparam int AW     = $clog2(WIDTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic rob_rpt_vld, iq_rpt_vld, lsq_rpt_vld, rob_empty;
  logic [CNT_W-1:0] rob_rpt, iq_rpt, lsq_rpt, disp_last, lsq_disp_last, avail;
  logic [WIDTH*DST_W-1:0] slot_dst;
  logic [WIDTH-1:0] slot_sb, slot_sa;
  logic [PREG_W-1:0] preg_free;
  logic [AW-1:0] admit;
  logic block_req, ser_stall, inflight_uflow;
  logic [1:0] cause;

  always #5 clk = ~clk;

  rn_admit #(.WIDTH(WIDTH), .CNT_W(CNT_W), .DST_W(DST_W), .PREG_W(PREG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .rob_rpt_vld(rob_rpt_vld), .rob_rpt(rob_rpt),
    .iq_rpt_vld(iq_rpt_vld), .iq_rpt(iq_rpt),
    .lsq_rpt_vld(lsq_rpt_vld), .lsq_rpt(lsq_rpt),
    .disp_last(disp_last), .lsq_disp_last(lsq_disp_last),
    .avail(avail), .slot_dst(slot_dst), .slot_sb(slot_sb), .slot_sa(slot_sa),
    .preg_free(preg_free), .rob_empty(rob_empty),
    .admit(admit), .block_req(block_req), .ser_stall(ser_stall),
    .cause(cause), .inflight_uflow(inflight_uflow)
  );

  // Staged stimulus, applied just after a falling edge
  int s_rob_v, s_rob, s_iq_v, s_iq, s_lsq_v, s_lsq, s_disp, s_ldisp, s_avail, s_preg, s_empty;
  int s_dst [WIDTH];
  int s_sb  [WIDTH];
  int s_sa  [WIDTH];

  // Bench model state
  int m_rob, m_iq, m_lsq, m_inf, m_stall, m_pend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_stage();
    s_rob_v = 0; s_iq_v = 0; s_lsq_v = 0;
    s_rob = 0; s_iq = 0; s_lsq = 0;
    s_disp = 0; s_ldisp = 0; s_avail = 0; s_preg = 20; s_empty = 0;
    for (int i = 0; i < WIDTH; i++) begin
      s_dst[i] = 1; s_sb[i] = 0; s_sa[i] = 0;
    end
  endtask

  task automatic cyc(string tag);
    int e_rob, e_iq, e_lsq, mn, src, exitc, hold, bypass, lim, qcap;
    int cnt, cum, sbhit, go, mark, e_block, e_stall, e_cause, nx, uf, lastsa;
    @(negedge clk);
    rob_rpt_vld = 1'(s_rob_v); rob_rpt = CNT_W'(s_rob);
    iq_rpt_vld  = 1'(s_iq_v);  iq_rpt  = CNT_W'(s_iq);
    lsq_rpt_vld = 1'(s_lsq_v); lsq_rpt = CNT_W'(s_lsq);
    disp_last = CNT_W'(s_disp); lsq_disp_last = CNT_W'(s_ldisp);
    avail = CNT_W'(s_avail); preg_free = PREG_W'(s_preg); rob_empty = 1'(s_empty);
    for (int i = 0; i < WIDTH; i++) begin
      slot_dst[i*DST_W +: DST_W] = DST_W'(s_dst[i]);
      slot_sb[i] = 1'(s_sb[i]);
      slot_sa[i] = 1'(s_sa[i]);
    end
    #1;
    // R1 R2: usable space per queue
    e_rob = m_rob - m_inf + s_disp;
    e_iq  = m_iq  - m_inf + s_disp;
    e_lsq = m_lsq - m_inf + s_ldisp;
    // R3: tie order
    mn = e_rob; src = 1;
    if (e_iq < mn)  begin mn = e_iq;  src = 2; end
    if (e_lsq < mn) begin mn = e_lsq; src = 3; end
    exitc  = (s_empty != 0 && m_inf == 0) ? 1 : 0;
    hold   = (m_stall != 0 && exitc == 0) ? 1 : 0;
    bypass = (m_stall != 0 && exitc != 0) ? 1 : 0;
    qcap = (mn <= 0) ? 0 : mn;
    lim = qcap;
    if (s_avail < lim) lim = s_avail;
    if (WIDTH < lim) lim = WIDTH;
    if (hold != 0) lim = 0;
    cnt = 0; cum = 0; sbhit = 0; go = 1;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == 0) mark = (s_sb[0] != 0 || (m_pend != 0 && exitc == 0)) && bypass == 0;
      else        mark = (s_sb[i] != 0 || s_sa[i-1] != 0);
      if (go != 0 && i < lim) begin
        if (mark != 0) begin sbhit = 1; go = 0; end
        else if (cum + s_dst[i] > s_preg) go = 0;
        else begin cum += s_dst[i]; cnt++; end
      end
    end
    e_block = (hold != 0 || cnt < s_avail) ? 1 : 0;
    e_stall = (hold != 0 || sbhit != 0) ? 1 : 0;
    e_cause = (hold == 0 && s_avail > 0 && mn < s_avail) ? src : 0;
    nx = m_inf + cnt - s_disp;
    uf = (nx < 0) ? 1 : 0;
    if (nx < 0) nx = 0;
    if (nx > 63) nx = 63;
    lastsa = (cnt > 0) ? s_sa[cnt-1] : 0;

    chk(tag, "admit", int'(admit), cnt);
    chk(tag, "block_req", int'(block_req), e_block);
    chk(tag, "ser_stall", int'(ser_stall), e_stall);
    chk(tag, "cause", int'(cause), e_cause);
    chk(tag, "inflight_uflow", int'(inflight_uflow), uf);

    // R8 R9: pending mark update
    m_pend  = ((lastsa != 0 && sbhit == 0) || (m_pend != 0 && exitc == 0 && lim == 0)) ? 1 : 0;
    m_stall = e_stall;
    m_inf   = nx;
    // R11: store only on valid
    if (s_rob_v != 0) m_rob = s_rob;
    if (s_iq_v  != 0) m_iq  = s_iq;
    if (s_lsq_v != 0) m_lsq = s_lsq;
  endtask

  task automatic report_all(int r, int q, int l);
    s_rob_v = 1; s_rob = r; s_iq_v = 1; s_iq = q; s_lsq_v = 1; s_lsq = l;
  endtask

  task automatic no_report();
    s_rob_v = 0; s_iq_v = 0; s_lsq_v = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_rob = 0; m_iq = 0; m_lsq = 0; m_inf = 0; m_stall = 0; m_pend = 0;
    clear_stage();
    rst_n = 1'b0;
    rob_rpt_vld = 0; iq_rpt_vld = 0; lsq_rpt_vld = 0; rob_empty = 0;
    rob_rpt = '0; iq_rpt = '0; lsq_rpt = '0; disp_last = '0; lsq_disp_last = '0;
    avail = '0; slot_dst = '0; slot_sb = '0; slot_sa = '0; preg_free = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state refuses offers, tie gives reorder buffer as cause
    s_avail = 3; cyc("R12");
    // R11: report arrives, not yet usable this cycle
    report_all(10, 5, 8); cyc("R11");
    // R11: invalid reports ignored; R5 full width admitted
    s_rob_v = 0; s_iq_v = 0; s_lsq_v = 0; s_rob = 50; s_iq = 50; s_lsq = 50;
    s_avail = 4; cyc("R5");
    // R1: issue queue charged by four in flight
    cyc("R1");
    // R2: dispatch credits main queues, not the load/store queue
    s_disp = 5; s_ldisp = 0; cyc("R2");
    // R4: load/store queue reported empty
    s_disp = 0; s_lsq_v = 1; s_lsq = 0; cyc("R4");
    no_report(); s_avail = 2; cyc("R4");
    // R10: oversized dispatch count clamps in-flight
    report_all(30, 30, 30); s_disp = 40; s_ldisp = 40; cyc("R10");
    no_report(); s_disp = 0; s_ldisp = 0; s_avail = 0; cyc("R10");
    // R6: register shortage
    s_avail = 3; s_preg = 2; s_dst[0] = 1; s_dst[1] = 3; cyc("R6");
    s_preg = 20; s_dst[1] = 1;
    // R7: serialize-before on slot 1, hold, then release
    s_sb[1] = 1; s_empty = 0; cyc("R7");
    s_sb[1] = 0; s_sb[0] = 1; cyc("R7");
    s_empty = 1; s_disp = 30; cyc("R7");
    s_disp = 0; cyc("R7");
    s_sb[0] = 0; s_empty = 0; cyc("R7");
    // R8: serialize-after in last admitted slot carries to next cycle
    s_disp = 30; cyc("R8");
    s_disp = 0; s_avail = 2; s_sa[1] = 1; cyc("R8");
    s_sa[1] = 0; cyc("R8");
    s_empty = 1; s_disp = 30; cyc("R8");
    s_disp = 0; cyc("R8");
    // R9: pending mark dropped when drained
    s_empty = 0; s_sa[1] = 1; s_disp = 30; cyc("R9");
    s_sa[1] = 0; s_disp = 0; s_empty = 1; cyc("R9");
    // R3: equal spaces, tie order
    s_empty = 0; s_disp = 30; report_all(2, 2, 2); s_avail = 0; cyc("R3");
    no_report(); s_disp = 0; s_avail = 4; cyc("R3");
    report_all(9, 2, 1); s_disp = 30; s_ldisp = 30; s_avail = 0; cyc("R3");
    no_report(); s_disp = 0; s_ldisp = 0; s_avail = 4; cyc("R3");

    // Seeded random mix
    for (int n = 0; n < 4000; n++) begin
      s_rob_v = ($urandom_range(0, 3) == 0) ? 1 : 0; s_rob = int'($urandom_range(0, 40));
      s_iq_v  = ($urandom_range(0, 3) == 0) ? 1 : 0; s_iq  = int'($urandom_range(0, 40));
      s_lsq_v = ($urandom_range(0, 3) == 0) ? 1 : 0; s_lsq = int'($urandom_range(0, 40));
      s_disp  = ($urandom_range(0, 15) == 0) ? m_inf + 2 : int'($urandom_range(0, 3));
      if (s_disp > 63) s_disp = 63;
      s_ldisp = int'($urandom_range(0, 3));
      s_avail = int'($urandom_range(0, 6));
      s_preg  = int'($urandom_range(0, 12));
      s_empty = ($urandom_range(0, 2) == 0) ? 1 : 0;
      for (int i = 0; i < WIDTH; i++) begin
        s_dst[i] = int'($urandom_range(0, 3));
        s_sb[i]  = ($urandom_range(0, 9) == 0) ? 1 : 0;
        s_sa[i]  = ($urandom_range(0, 9) == 0) ? 1 : 0;
      end
      cyc("RND");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule